// File: doc/BRIEF.md
# Interrupt Request Arming and Line Generation

This block keeps the interrupt arming state of a polled peripheral controller and produces the interrupt lines that go to the host. Software arms or disarms interrupts by writing a 16-bit function word. The word is qualified by a function-write strobe that the address decoder has already produced. Three arming flags control the lines: data, end-of-operation and alarm. Each line is raised only while its flag is set and the matching live status condition holds. A fourth, common line is the OR of the three, and the same summary appears as a bit in the controller's status word.

The function word is acted on when the strobe ends. The word that counts is the last one present while the strobe was high. Clear bits in the word drop every flag. Request bits set their flag, and a request wins over a clear carried in the same word.

The two event-style sources behave differently. An alarm that is already present when its flag is armed raises the alarm line at once. An end-of-operation that finished before arming never raises the line. Only a completion seen after the flag is set counts. Master clear overrides everything. All interfaces are plain control and status levels, with no data stream and so no back-pressure.

Top module: `irqc_top`

## Requirements
- R1: Arming state changes only in the clock cycle in which the sampled strobe `fn_wr` goes from 1 to 0. That cycle uses the last `fn_word` sampled while `fn_wr` was 1, and while the strobe stays high the lines do not change because of the word.
- R2: A committed word with bit 2, bit 3 or bit 4 set arms the data, end-of-operation or alarm flag respectively.
- R3: A committed word with bit 0 or bit 1 set, and no request bit, disarms all three flags and discards any end-of-operation completion already recorded.
- R4: When request bits and clear bits are committed together, the requested flags end up armed and all other flags end up disarmed.
- R5: `irq_data` equals the data flag AND `st_data`, and `irq_alarm` equals the alarm flag AND `st_alarm`. `irq_eop` is high only while its flag is armed, `st_eop` is high, and a completion has been recorded.
- R6: `irq_any` is high exactly when at least one of `irq_data`, `irq_eop` or `irq_alarm` is high.
- R7: Arming the alarm flag while `st_alarm` is already high raises `irq_alarm` in the commit cycle.
- R8: A completion is a 0-to-1 change of `st_eop` sampled while the end-of-operation flag is already armed. It stays recorded until `st_eop` returns to 0 or a clear happens. An `st_eop` that was already high at arming does not raise `irq_eop`.
- R9: A sampled `mclr` disarms all flags and discards the recorded completion, and it takes priority over a commit in the same cycle.
- R10: Output `stat_int` (bit 2 of the status word) always equals `irq_any`.
- R11: Bits 5 to 15 of the function word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| fn_wr | input | 1 | Decoded function-write strobe, level, acted on at its end |
| fn_word | input | 16 | Function word qualified by the strobe |
| st_data | input | 1 | Live data-available condition |
| st_eop | input | 1 | Live end-of-operation condition |
| st_alarm | input | 1 | Live alarm condition |
| irq_data | output | 1 | Data interrupt line |
| irq_eop | output | 1 | End-of-operation interrupt line |
| irq_alarm | output | 1 | Alarm interrupt line |
| irq_any | output | 1 | Common interrupt line |
| stat_int | output | 1 | Interrupt summary bit for the status word |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that the `fn_word` a check relies on is the one held during the strobe's last high cycle. Because each property reads the word through a one-cycle look-back at the fall of `fn_wr`, the stimulus holds the word for the whole strobe and never lowers the strobe in the same cycle that it changes the word. The random phase draws status levels that change slowly, so that completions occur both before and after arming. It also draws strobes from one to three cycles long, with words that mix clear bits, request bits and the ignored upper bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int FN_W      = 16;
  localparam int NSRC      = 3;
  localparam int CLR_CTL_B = 0;
  localparam int CLR_INT_B = 1;
  localparam int REQ_LSB   = 2;
  localparam int REQ_MSB   = REQ_LSB + NSRC - 1;

  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_EOP   = 2'd1,
    SRC_ALARM = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irqc_wr_edge.sv
module irqc_wr_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] word,
  output logic         commit,
  output logic [W-1:0] held
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      held <= '0;
    end else begin
      wr_q <= wr;
      if (wr) held <= word;
    end
  end

  // trailing edge of the strobe
  assign commit = wr_q & ~wr;
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mclr,
  input  logic         commit,
  input  logic         clr_all,
  input  logic [N-1:0] req,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag[i] <= 1'b0;
      else if (mclr)            flag[i] <= 1'b0;
      else if (commit) begin
        if (req[i])             flag[i] <= 1'b1;
        else if (clr_all)       flag[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqc_eop_track.sv
module irqc_eop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mclr,
  input  logic clr_now,
  input  logic armed,
  input  logic done_lvl,
  output logic pend
);
  logic done_q;
  logic rise;

  assign rise = done_lvl & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      done_q <= done_lvl;
      if (mclr || clr_now)      pend <= 1'b0;
      else if (!done_lvl)       pend <= 1'b0;
      else if (rise && armed)   pend <= 1'b1;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int FW = FN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr,
  input  logic          fn_wr,
  input  logic [FW-1:0] fn_word,
  input  logic          st_data,
  input  logic          st_eop,
  input  logic          st_alarm,
  output logic          irq_data,
  output logic          irq_eop,
  output logic          irq_alarm,
  output logic          irq_any,
  output logic          stat_int
);
  logic          commit;
  logic [FW-1:0] held;
  logic          clr_all;
  logic [NSRC-1:0] req, flag, cond, line;
  logic          eop_pend;

  irqc_wr_edge #(.W(FW)) u_edge (
    .clk(clk), .rst_n(rst_n), .wr(fn_wr), .word(fn_word),
    .commit(commit), .held(held)
  );

  assign clr_all = held[CLR_CTL_B] | held[CLR_INT_B];
  assign req     = held[REQ_MSB:REQ_LSB];

  irqc_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .commit(commit),
    .clr_all(clr_all), .req(req), .flag(flag)
  );

  irqc_eop_track u_eop (
    .clk(clk), .rst_n(rst_n), .mclr(mclr),
    .clr_now(commit & clr_all),
    .armed(flag[SRC_EOP]), .done_lvl(st_eop), .pend(eop_pend)
  );

  assign cond[SRC_DATA]  = st_data;
  assign cond[SRC_EOP]   = st_eop & eop_pend;
  assign cond[SRC_ALARM] = st_alarm;

  for (genvar i = 0; i < NSRC; i++) begin : g_line
    assign line[i] = flag[i] & cond[i];
  end

  assign irq_data  = line[SRC_DATA];
  assign irq_eop   = line[SRC_EOP];
  assign irq_alarm = line[SRC_ALARM];
  assign irq_any   = |line;
  assign stat_int  = irq_any;
endmodule

// File: rtl/irqc_top_chk.sv
module irqc_top_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mclr,
  input logic          fn_wr,
  input logic [FW-1:0] fn_word,
  input logic          st_eop,
  input logic          st_alarm,
  input logic          irq_eop,
  input logic          irq_alarm,
  input logic          irq_any
);
  // R3: a clear-only word silences every line
  a_r3_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fn_wr) && $past(fn_word[1:0] != 2'b00) && $past(fn_word[4:2] == 3'b000))
    |=> !irq_any);

  // R9: master clear silences every line
  a_r9_mclr_silences: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> !irq_any);

  // R7 and R4: arming alarm follows the present alarm level at once, even with a clear
  a_r7_alarm_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fn_wr) && $past(fn_word[4]) && !mclr) |=> (irq_alarm == st_alarm));

  // R8: arming never creates an end-of-operation interrupt by itself
  a_r8_no_stale_eop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fn_wr) && $past(fn_word[3]) && !irq_eop && !$rose(st_eop)) |=> !irq_eop);

  // R1: a strobe still high commits nothing, so an idle line stays idle
  a_r1_no_commit_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_wr && !irq_eop && !$rose(st_eop)) |=> !irq_eop);
endmodule

bind irqc_top irqc_top_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mclr(mclr), .fn_wr(fn_wr), .fn_word(fn_word),
  .st_eop(st_eop), .st_alarm(st_alarm), .irq_eop(irq_eop),
  .irq_alarm(irq_alarm), .irq_any(irq_any)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 1'b0;
  logic fn_wr = 1'b0;
  logic [15:0] fn_word = '0;
  logic st_data = 1'b0, st_eop = 1'b0, st_alarm = 1'b0;
  logic irq_data, irq_eop, irq_alarm, irq_any, stat_int;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic m_wq = 1'b0, m_eq = 1'b0, m_pend = 1'b0;
  logic [15:0] m_hold = '0;
  logic [2:0] m_flag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .fn_wr(fn_wr), .fn_word(fn_word),
    .st_data(st_data), .st_eop(st_eop), .st_alarm(st_alarm),
    .irq_data(irq_data), .irq_eop(irq_eop), .irq_alarm(irq_alarm),
    .irq_any(irq_any), .stat_int(stat_int)
  );

  function automatic logic [3:0] expect_lines();
    logic d, e, a;
    d = m_flag[0] & st_data;
    e = m_flag[1] & m_pend & st_eop;
    a = m_flag[2] & st_alarm;
    return {d | e | a, a, e, d};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    logic [3:0] e;
    e = expect_lines();
    chk({tag, " R5 data"}, irq_data, e[0]);
    chk({tag, " R5 R8 eop"}, irq_eop, e[1]);
    chk({tag, " R5 R7 alarm"}, irq_alarm, e[2]);
    chk({tag, " R6 common"}, irq_any, e[3]);
    chk({tag, " R10 status bit"}, stat_int, e[3]);
  endtask

  // advance one clock: model follows the inputs sampled at the edge
  task automatic tick();
    logic commit, clr, rise, pend_n;
    logic [2:0] flag_n;
    commit = m_wq & ~fn_wr;
    clr = m_hold[0] | m_hold[1];
    rise = st_eop & ~m_eq;
    flag_n = m_flag;
    pend_n = m_pend;
    if (mclr) begin
      flag_n = '0; pend_n = 1'b0;
    end else begin
      if (commit) flag_n = (clr ? 3'b000 : m_flag) | m_hold[4:2];
      if (commit && clr) pend_n = 1'b0;
      else if (!st_eop) pend_n = 1'b0;
      else if (rise && m_flag[1]) pend_n = 1'b1;
    end
    @(posedge clk);
    m_flag = flag_n; m_pend = pend_n;
    m_eq = st_eop; m_wq = fn_wr;
    if (fn_wr) m_hold = fn_word;
    @(negedge clk);
  endtask

  task automatic write_fn(input logic [15:0] w);
    fn_wr = 1'b1; fn_word = w;
    tick();
    fn_wr = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    st_data = 1'b1; st_eop = 1'b1; st_alarm = 1'b1;
    repeat (3) @(negedge clk);
    check_all("reset");
    rst_n = 1'b1;
    st_eop = 1'b0;
    tick();
    check_all("idle");

    // R7 alarm already present at arming
    write_fn(16'h0010);
    chk("R7 alarm immediate", irq_alarm, 1'b1);
    check_all("R2 arm alarm");

    // R1 strobe held high: no change before the fall
    fn_wr = 1'b1; fn_word = 16'h0004;
    tick();
    chk("R1 data not armed while strobe high", irq_data, 1'b0);
    tick();
    chk("R1 still not armed", irq_data, 1'b0);
    fn_wr = 1'b0;
    tick();
    chk("R1 armed after trailing edge", irq_data, 1'b1);

    // R8 completion already present at arming
    st_eop = 1'b1; tick();
    write_fn(16'h0008);
    chk("R8 stale completion ignored", irq_eop, 1'b0);
    st_eop = 1'b0; tick();
    st_eop = 1'b1; tick();
    chk("R8 new completion raises eop", irq_eop, 1'b1);

    // R11 upper bits ignored
    write_fn(16'hFFE0);
    check_all("R11 upper bits");
    chk("R11 eop unchanged", irq_eop, 1'b1);

    // R4 request beats clear in same word
    write_fn(16'h0007);
    chk("R4 data kept by request", irq_data, 1'b1);
    chk("R4 alarm dropped by clear", irq_alarm, 1'b0);
    chk("R3 R4 eop dropped by clear", irq_eop, 1'b0);

    // R3 clear-only
    write_fn(16'h001C);
    write_fn(16'h0002);
    chk("R3 clear interrupts", irq_any, 1'b0);
    write_fn(16'h001C);
    write_fn(16'h0001);
    chk("R3 clear controller", irq_any, 1'b0);

    // R9 master clear beats commit in the same cycle
    fn_wr = 1'b1; fn_word = 16'h0014; tick();
    fn_wr = 1'b0; mclr = 1'b1; tick();
    mclr = 1'b0;
    chk("R9 mclr over commit", irq_any, 1'b0);
    check_all("R9");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int len;
      if ($urandom_range(0, 3) == 0) begin
        fn_word = 16'($urandom());
        if ($urandom_range(0, 1) == 0) fn_word[1:0] = 2'b00;
        fn_wr = 1'b1;
        len = $urandom_range(1, 3);
        for (int k = 0; k < len; k++) begin
          tick();
          check_all("rand strobe R1");
        end
        fn_wr = 1'b0;
      end
      if ($urandom_range(0, 5) == 0) st_eop = ~st_eop;
      if ($urandom_range(0, 5) == 0) st_alarm = ~st_alarm;
      if ($urandom_range(0, 3) == 0) st_data = ~st_data;
      mclr = ($urandom_range(0, 60) == 0);
      tick();
      mclr = 1'b0;
      check_all("rand");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule